// File: doc/BRIEF.md
# Paged PHY Register Access Engine

This block lets a host reach registers inside external Ethernet PHYs that are organised in pages. The host loads a small set of control words, which select the PHY, the page, the register within the page, the direction and the data, and then sets a start bit. The engine first writes the page number into the PHY's page-select register. It then performs the actual read or write of the target register. Both accesses use standard Clause 22 management frames on an MDC/MDIO pair.

A read addresses one PHY, chosen by a port number. The 16-bit result lands in the low half of the data word. A write addresses PHYs through a port bitmask. Every selected port receives its own page-select and write pair, starting at the lowest port number. Some fields of the command word are never touched by the engine: the park-page field and one spare flag. Software can keep state there across commands. Argument checks run when the start bit is written, and a command that fails them produces no bus traffic.

Top module: `phy_paged_mdio`

## Requirements
- R1: After reset, all four host words read 0, MDC is low and the MDIO output enable is low.
- R2: Writing the command word (address 1) with bit 0 set while idle starts an operation. Bit 0 then reads 1 until the operation completes, and reads 0 afterwards.
- R3: When an operation completes, every command-word bit other than bit 0 keeps the value the host wrote. This covers the register number in bits 24:20, the park page in bits 19:15, the page in bits 14:3, the write flag in bit 2 (1 = write) and the spare flag in bit 1.
- R4: While bit 0 of the command word is 1, host writes to any address are ignored.
- R5: Each per-port access is two frames to the same PHY address. The first is a write of the page value, zero-extended to 16 bits, to register 31. The second is the read or write of the target register.
- R6: Every frame carries the following fields, in order: 32 ones, start 01, opcode (01 = write, 10 = read), PHY address (5 bits, MSB first), register (5 bits, MSB first), turnaround, then 16 data bits MSB first. On a write the turnaround is 10. On a read the engine releases MDIO from the first turnaround bit to the end of the frame.
- R7: MDC has a high phase of exactly CLK_DIV/2 clocks and a low phase of at least CLK_DIV/2 clocks. The engine's MDIO output and output enable change only while MDC is low.
- R8: A read takes its port from data-word (address 2) bits 31:16 and samples MDIO on MDC rising edges. It stores the result in data-word bits 15:0 and leaves bits 31:16 unchanged.
- R9: A write uses the port mask in address 0 and the data in address 2 bits 31:16. It visits each set mask bit in ascending port order.
- R10: A read whose port number is 32 or above produces 0xFFFF in data-word bits 15:0. It causes no bus frame and does not set the error flag. Bit 0 reads 0 in the next cycle.
- R11: A write with an all-zero mask sets the error flag (address 3 bit 0), causes no bus frame, and bit 0 reads 0 in the next cycle. The next accepted start clears the error flag.
- R12: Whenever bit 0 of the command word is 0, MDC is low and the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Host word select: 0 mask, 1 command, 2 data, 3 status |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected word (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the engine |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line value as seen at the pad |

## Verification
Host register writes and an operation in flight can meet in the same cycle. The bench provokes this by writing the mask, command and data words while a read is still busy. It then judges the result by reading the words back after completion, and all three must hold their pre-start values. A second overlap is the final frame's completion and the busy flag falling. The bench checks that, at the first cycle the start bit reads 0, the bus is already quiet and the read result is already in place. A PHY model in the bench decodes every frame and logs it, so the frame order, page-select writes and read responses are all compared against sequences the bench computes.

// File: rtl/phy_mdio_pkg.sv
// Package: shared constants and types of the paged PHY access engine.
// Assumes Clause 22 framing (5-bit PHY and register addresses).
package phy_mdio_pkg;
    localparam int PHY_AW      = 5;
    localparam int FRAME_BITS  = 64;
    localparam logic [4:0] PAGE_SEL_REG = 5'd31;

    // host word addresses
    localparam logic [1:0] HA_MASK = 2'd0;
    localparam logic [1:0] HA_CMD  = 2'd1;
    localparam logic [1:0] HA_DATA = 2'd2;
    localparam logic [1:0] HA_STAT = 2'd3;

    // command word field positions (host-visible layout)
    localparam int CMD_GO    = 0;
    localparam int CMD_WR    = 2;
    localparam int CMD_PG_LO = 3;
    localparam int CMD_RG_LO = 20;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_PAGE   = 2'd1,
        SQ_TARGET = 2'd2
    } seq_phase_t;
endpackage

// File: rtl/mdc_tick_gen.sv
// mdc_tick_gen: produces MDC from the system clock while enabled.
// Assumes CLK_DIV is even and at least 2. MDC is held low when disabled.
// rise_tick / fall_tick are high in the cycle whose edge flips MDC.
module mdc_tick_gen #(
    parameter int CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap      = (cnt_q == CW'(HALF - 1));
    assign rise_tick = en && wrap && !mdc;
    assign fall_tick = en && wrap && mdc;

    // half-period counter and MDC toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
// mdio_frame_engine: shifts one 64-bit Clause 22 frame onto MDIO.
// Output bits change on MDC falling ticks; read data is sampled on
// rising ticks. Inputs are captured on start; start is ignored while active.
module mdio_frame_engine
    import phy_mdio_pkg::*;
#(
    parameter int CLK_DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_read,
    input  logic [PHY_AW-1:0] phy_addr,
    input  logic [4:0]        reg_addr,
    input  logic [15:0]       wdata,
    input  logic              mdio_i,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [15:0]       rdata,
    output logic              done
);
    logic                  active_q;
    logic                  rd_q;
    logic [5:0]            idx_q;
    logic [FRAME_BITS-1:0] sh_q;
    logic [FRAME_BITS-1:0] frame;
    logic                  rise_tick, fall_tick;
    logic [5:0]            idx_nxt;

    mdc_tick_gen #(.CLK_DIV(CLK_DIV)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (active_q),
        .mdc      (mdc),
        .rise_tick(rise_tick),
        .fall_tick(fall_tick)
    );

    // assemble the frame from captured arguments
    always_comb begin
        if (is_read)
            frame = {32'hFFFF_FFFF, 2'b01, 2'b10, phy_addr, reg_addr, 2'b11, 16'hFFFF};
        else
            frame = {32'hFFFF_FFFF, 2'b01, 2'b01, phy_addr, reg_addr, 2'b10, wdata};
    end

    assign idx_nxt = idx_q + 6'd1;

    // frame sequencing, bit shifting and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            rd_q     <= 1'b0;
            idx_q    <= '0;
            sh_q     <= '0;
            mdio_o   <= 1'b1;
            mdio_oe  <= 1'b0;
            rdata    <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active_q) begin
                if (start) begin
                    active_q <= 1'b1;
                    rd_q     <= is_read;
                    idx_q    <= '0;
                    sh_q     <= frame;
                    mdio_o   <= frame[FRAME_BITS-1];
                    mdio_oe  <= 1'b1;
                    rdata    <= '0;
                end
            end else begin
                if (rise_tick && rd_q && (idx_q >= 6'd48))
                    rdata <= {rdata[14:0], mdio_i};
                if (fall_tick) begin
                    if (idx_q == 6'd63) begin
                        active_q <= 1'b0;
                        done     <= 1'b1;
                        mdio_oe  <= 1'b0;
                        mdio_o   <= 1'b1;
                    end else begin
                        idx_q   <= idx_nxt;
                        sh_q    <= {sh_q[FRAME_BITS-2:0], 1'b0};
                        mdio_o  <= sh_q[FRAME_BITS-2];
                        mdio_oe <= !(rd_q && (idx_nxt >= 6'd46));
                    end
                end
            end
        end
    end
endmodule

// File: rtl/port_pick.sv
// port_pick: returns the lowest set bit index of a port mask.
// Assumes N fits in IW bits of index.
module port_pick #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic [N-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic          any
);
    // scan from the top so the lowest set bit wins
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (mask[i]) idx = IW'(i);
        any = |mask;
    end
endmodule

// File: rtl/phy_paged_mdio.sv
// phy_paged_mdio: host word interface plus the sequencer that turns one
// command into page-select / target frame pairs, one pair per port.
// Assumes N_PORTS <= 32; host reads are combinational.
module phy_paged_mdio
    import phy_mdio_pkg::*;
#(
    parameter int CLK_DIV = 8,
    parameter int N_PORTS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [1:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam logic [15:0] PORT_LIM = 16'(N_PORTS);

    logic [31:0]        ctrl0_q, ctrl1_q, ctrl2_q;
    logic               err_q;
    seq_phase_t         phase_q;
    logic [N_PORTS-1:0] rem_q;
    logic [PHY_AW-1:0]  cur_q;
    logic               launch_q;

    logic               busy;
    logic [N_PORTS-1:0] mask0, cur_bit, rem_nxt;
    logic [PHY_AW-1:0]  pick0_idx, pickn_idx;
    logic               pick0_any, pickn_any;
    logic               fr_read, fr_done;
    logic [4:0]         fr_reg;
    logic [15:0]        fr_data, fr_rdata;

    assign busy  = ctrl1_q[CMD_GO];
    assign mask0 = ctrl0_q[N_PORTS-1:0];

    // one-hot of the port currently served
    always_comb begin
        cur_bit        = '0;
        cur_bit[cur_q] = 1'b1;
        rem_nxt        = rem_q & ~cur_bit;
    end

    port_pick #(.N(N_PORTS), .IW(PHY_AW)) u_pick_first (
        .mask(mask0), .idx(pick0_idx), .any(pick0_any)
    );
    port_pick #(.N(N_PORTS), .IW(PHY_AW)) u_pick_next (
        .mask(rem_nxt), .idx(pickn_idx), .any(pickn_any)
    );

    // frame arguments for the current phase
    always_comb begin
        fr_read = (phase_q == SQ_TARGET) && !ctrl1_q[CMD_WR];
        fr_reg  = (phase_q == SQ_PAGE) ? PAGE_SEL_REG : ctrl1_q[CMD_RG_LO +: 5];
        fr_data = (phase_q == SQ_PAGE) ? {4'b0, ctrl1_q[CMD_PG_LO +: 12]} : ctrl2_q[31:16];
    end

    mdio_frame_engine #(.CLK_DIV(CLK_DIV)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (launch_q),
        .is_read (fr_read),
        .phy_addr(cur_q),
        .reg_addr(fr_reg),
        .wdata   (fr_data),
        .mdio_i  (mdio_i),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rdata   (fr_rdata),
        .done    (fr_done)
    );

    // host writes, argument checks and per-port sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl0_q  <= '0;
            ctrl1_q  <= '0;
            ctrl2_q  <= '0;
            err_q    <= 1'b0;
            phase_q  <= SQ_IDLE;
            rem_q    <= '0;
            cur_q    <= '0;
            launch_q <= 1'b0;
        end else begin
            launch_q <= 1'b0;
            if (!busy && host_we) begin
                case (host_addr)
                    HA_MASK: ctrl0_q <= host_wdata;
                    HA_CMD: begin
                        ctrl1_q <= host_wdata;
                        if (host_wdata[CMD_GO]) begin
                            err_q <= 1'b0;
                            if (host_wdata[CMD_WR]) begin
                                if (!pick0_any) begin
                                    ctrl1_q[CMD_GO] <= 1'b0;
                                    err_q           <= 1'b1;
                                end else begin
                                    rem_q    <= mask0;
                                    cur_q    <= pick0_idx;
                                    phase_q  <= SQ_PAGE;
                                    launch_q <= 1'b1;
                                end
                            end else if (ctrl2_q[31:16] >= PORT_LIM) begin
                                ctrl1_q[CMD_GO] <= 1'b0;
                                ctrl2_q[15:0]   <= 16'hFFFF;
                            end else begin
                                cur_q    <= ctrl2_q[16 +: PHY_AW];
                                phase_q  <= SQ_PAGE;
                                launch_q <= 1'b1;
                            end
                        end
                    end
                    HA_DATA: ctrl2_q[31:16] <= host_wdata[31:16];
                    default: ;
                endcase
            end else if (busy && fr_done) begin
                if (phase_q == SQ_PAGE) begin
                    phase_q  <= SQ_TARGET;
                    launch_q <= 1'b1;
                end else if (!ctrl1_q[CMD_WR]) begin
                    ctrl2_q[15:0]   <= fr_rdata;
                    ctrl1_q[CMD_GO] <= 1'b0;
                    phase_q         <= SQ_IDLE;
                end else if (pickn_any) begin
                    rem_q    <= rem_nxt;
                    cur_q    <= pickn_idx;
                    phase_q  <= SQ_PAGE;
                    launch_q <= 1'b1;
                end else begin
                    rem_q           <= '0;
                    ctrl1_q[CMD_GO] <= 1'b0;
                    phase_q         <= SQ_IDLE;
                end
            end
        end
    end

    // host read mux
    always_comb begin
        case (host_addr)
            HA_MASK: host_rdata = ctrl0_q;
            HA_CMD:  host_rdata = ctrl1_q;
            HA_DATA: host_rdata = ctrl2_q;
            default: host_rdata = {31'b0, err_q};
        endcase
    end
endmodule

// File: rtl/phy_paged_mdio_chk.sv
// phy_paged_mdio_chk: temporal properties of phy_paged_mdio, attached by bind.
module phy_paged_mdio_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_we,
    input logic [31:0] ctrl0_q,
    input logic [31:0] ctrl1_q,
    input logic        err_q,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    // completion only drops the go bit
    p_fields_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl1_q[0]) |-> (ctrl1_q[31:1] == $past(ctrl1_q[31:1])));

    // host writes while busy leave the mask alone
    p_busy_ignores_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl1_q[0] && host_we) |=> $stable(ctrl0_q));

    // MDIO moves only while MDC is low
    p_mdio_stable_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // an argument error raises no bus activity
    p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> (!mdio_oe && !mdc));

    // idle means a quiet bus
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl1_q[0] |-> (!mdio_oe && !mdc));
endmodule

bind phy_paged_mdio phy_paged_mdio_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .host_we(host_we),
    .ctrl0_q(ctrl0_q),
    .ctrl1_q(ctrl1_q),
    .err_q  (err_q),
    .mdc    (mdc),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe)
);

// File: tb/tb_phy_paged_mdio.sv
`timescale 1ns/1ps
module tb_phy_paged_mdio;
    localparam int CLK_DIV = 4;
    localparam int HALF    = CLK_DIV / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;
    logic        phy_drv = 1'b0, phy_bit = 1'b1;

    int n_cmp = 0, n_bad = 0;
    bit reported = 0;

    always #5 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);

    phy_paged_mdio #(.CLK_DIV(CLK_DIV), .N_PORTS(32)) dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // ---------------- PHY responder and frame log ----------------
    logic [15:0] pmem [int];
    logic [11:0] pg [32];
    int  lg_phy [1024], lg_reg [1024], lg_wr [1024];
    logic [15:0] lg_dat [1024];
    int  log_n = 0, bad_frames = 0;
    bit  in_frame = 0, cur_rd = 0;
    int  ones = 0, pos = 0, cur_phy = 0, cur_reg = 0;
    logic [63:0] fr = '0;
    logic [15:0] resp = '0;

    function automatic logic [15:0] dflt(int p, int page, int r);
        return 16'(p * 16'h0911 + page * 16'h0035 + r * 16'h1203) ^ 16'hA5C3;
    endfunction

    function automatic logic [15:0] model_get(int p, int page, int r);
        int key = (p << 17) | (page << 5) | r;
        if (r == 31) return {4'b0, pg[p]};
        if (pmem.exists(key)) return pmem[key];
        return dflt(p, page, r);
    endfunction

    // capture frames on MDC rising edges
    always @(posedge mdc) begin
        logic b;
        int idx;
        b = mdio_i;
        if (!in_frame) begin
            if (b) ones = ones + 1;
            else begin
                if (ones >= 32) begin in_frame = 1; pos = 33; end
                ones = 0;
            end
            fr = {fr[62:0], b};
        end else begin
            idx = pos;
            fr  = {fr[62:0], b};
            pos = pos + 1;
            if (idx == 45) begin
                if (fr[13:12] != 2'b01 || !(fr[11:10] == 2'b01 || fr[11:10] == 2'b10))
                    bad_frames++;
                cur_rd  = (fr[11:10] == 2'b10);
                cur_phy = int'(fr[9:5]);
                cur_reg = int'(fr[4:0]);
                if (cur_rd) resp = model_get(cur_phy, int'(pg[cur_phy]), cur_reg);
            end
            if (cur_rd && idx >= 46 && mdio_oe) bad_frames++;
            if (!cur_rd && idx == 46 && b != 1'b1) bad_frames++;
            if (!cur_rd && idx == 47 && b != 1'b0) bad_frames++;
            if (idx == 63) begin
                if (log_n < 1024) begin
                    lg_phy[log_n] = cur_phy; lg_reg[log_n] = cur_reg;
                    lg_wr[log_n]  = cur_rd ? 0 : 1;
                    lg_dat[log_n] = cur_rd ? resp : fr[15:0];
                    log_n++;
                end
                if (!cur_rd) begin
                    if (cur_reg == 31) pg[cur_phy] = fr[11:0];
                    else pmem[(cur_phy << 17) | (int'(pg[cur_phy]) << 5) | cur_reg] = fr[15:0];
                end
                in_frame = 0; ones = 0;
            end
        end
    end

    // PHY drives read data after MDC falls
    always @(negedge mdc) begin
        if (in_frame && cur_rd && pos >= 48 && pos <= 63) begin
            phy_drv = 1'b1; phy_bit = resp[63 - pos];
        end else begin
            phy_drv = 1'b0; phy_bit = 1'b1;
        end
    end

    // MDC phase lengths and MDIO stability (R7)
    int cyc = 0, last_rise = 0, last_fall = 0, timing_viol = 0;
    logic prev_mdc = 0, prev_o = 1, prev_oe = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mdc && !prev_mdc) begin
                if (cyc - last_fall < HALF) timing_viol++;
                last_rise = cyc;
            end
            if (!mdc && prev_mdc) begin
                if (cyc - last_rise != HALF) timing_viol++;
                last_fall = cyc;
            end
            if (mdc && prev_mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe)) timing_viol++;
        end
        prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
    end

    // ---------------- host helpers ----------------
    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hrd(logic [1:0] a, output logic [31:0] d);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 100000; i++) begin
            @(negedge clk);
            hrd(2'd1, v);
            if (!v[0]) break;
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // compare the log from base against the expected frame pairs
    task automatic chk_log(string req, int base, bit wr, logic [31:0] mask, int port,
                           logic [11:0] page, logic [4:0] rg, logic [15:0] dat);
        int k = base, mism = 0;
        for (int p = 0; p < 32; p++) begin
            if ((wr && mask[p]) || (!wr && p == port)) begin
                if (k + 1 >= log_n) mism++;
                else begin
                    if (lg_phy[k] != p || lg_reg[k] != 31 || lg_wr[k] != 1 ||
                        lg_dat[k] != {4'b0, page}) mism++;
                    if (lg_phy[k+1] != p || lg_reg[k+1] != int'(rg) ||
                        lg_wr[k+1] != int'(wr) || lg_dat[k+1] != dat) mism++;
                end
                k += 2;
            end
        end
        chk({req, " frame count"}, 32'(log_n), 32'(k));
        chk({req, " frame content mismatches"}, 32'(mism), 32'd0);
    endtask

    // run one valid operation and check it end to end (R2 R3 R5 R8 R9 R12)
    task automatic run_op(bit wr, logic [31:0] mask, int port, logic [11:0] page,
                          logic [4:0] rg, logic [15:0] wd);
        logic [31:0] cmd, v;
        logic [15:0] expd;
        int base;
        cmd  = {7'd0, rg, 5'($urandom), page, wr, 1'($urandom), 1'b1};
        expd = wr ? wd : model_get(port, int'(page), int'(rg));
        hwr(2'd0, mask);
        hwr(2'd2, {wr ? wd : 16'(port), 16'h0});
        base = log_n;
        hwr(2'd1, cmd);
        hrd(2'd1, v);
        chk("R2 go bit high while busy", {31'b0, v[0]}, 32'd1);
        wait_idle();
        hrd(2'd1, v);
        chk("R3 command fields kept", v, cmd & ~32'd1);
        chk("R12 idle bus quiet", {30'b0, mdc, mdio_oe}, 32'd0);
        if (wr) chk_log("R9 R5 write sequence", base, 1'b1, mask, 0, page, rg, wd);
        else begin
            chk_log("R5 read sequence", base, 1'b0, '0, port, page, rg, expd);
            hrd(2'd2, v);
            chk("R8 read result and port field", v, {16'(port), expd});
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end

    initial begin
        logic [31:0] v;
        int base;
        void'($urandom(32'd5179));
        for (int i = 0; i < 32; i++) pg[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            hrd(2'(a), v);
            chk("R1 reset word", v, 32'd0);
        end
        chk("R1 reset bus", {30'b0, mdc, mdio_oe}, 32'd0);

        // directed read and directed multi-port write
        run_op(1'b0, 32'h0, 3, 12'h005, 5'd7, 16'h0);
        run_op(1'b1, 32'h4000_0204, 0, 12'hABC, 5'd9, 16'hBEEF);
        run_op(1'b0, 32'h0, 9, 12'hABC, 5'd9, 16'h0);   // reads back BEEF
        chk("R9 write landed in PHY", 32'(model_get(30, 12'hABC, 9)), 32'h0000_BEEF);
        run_op(1'b1, 32'h8000_0001, 0, 12'hFFF, 5'd0, 16'h1234);

        // R4 host writes during busy are ignored
        hwr(2'd0, 32'h0000_0011);
        hwr(2'd2, 32'h0005_0000);
        hwr(2'd1, {7'd0, 5'd4, 5'h0A, 12'h077, 1'b0, 1'b0, 1'b1});
        hwr(2'd0, 32'hDEAD_BEEF);
        hwr(2'd2, 32'h1234_0000);
        hwr(2'd1, 32'h0);
        wait_idle();
        hrd(2'd0, v); chk("R4 mask unchanged", v, 32'h0000_0011);
        hrd(2'd1, v); chk("R4 command unchanged", v, {7'd0, 5'd4, 5'h0A, 12'h077, 3'b000});
        hrd(2'd2, v); chk("R4 port field unchanged", {16'b0, v[31:16]}, 32'd5);

        // R10 read of an out-of-range port
        base = log_n;
        hwr(2'd2, 32'h0028_0000);
        hwr(2'd1, {7'd0, 5'd2, 5'd0, 12'h001, 3'b001});
        hrd(2'd1, v); chk("R10 go bit already low", {31'b0, v[0]}, 32'd0);
        repeat (300) @(negedge clk);
        hrd(2'd2, v); chk("R10 all-ones result", v, 32'h0028_FFFF);
        hrd(2'd3, v); chk("R10 no error flag", v, 32'd0);
        chk("R10 no frames", 32'(log_n), 32'(base));

        // R11 write with empty mask, then cleared by a good start
        hwr(2'd0, 32'h0);
        hwr(2'd1, {7'd0, 5'd2, 5'd0, 12'h001, 3'b101});
        hrd(2'd1, v); chk("R11 go bit already low", {31'b0, v[0]}, 32'd0);
        repeat (300) @(negedge clk);
        hrd(2'd3, v); chk("R11 error flag set", v, 32'd1);
        chk("R11 no frames", 32'(log_n), 32'(base));
        run_op(1'b1, 32'h0000_0100, 0, 12'h010, 5'd3, 16'h00AA);
        hrd(2'd3, v); chk("R11 error cleared by next start", v, 32'd0);

        // constrained random mix
        for (int n = 0; n < 24; n++) begin
            logic [31:0] m;
            m = $urandom & $urandom & $urandom;
            if (m == 0) m = 32'h1 << ($urandom % 32);
            if ($urandom % 2)
                run_op(1'b1, m, 0, 12'($urandom), 5'($urandom % 31), 16'($urandom));
            else
                run_op(1'b0, '0, int'($urandom % 32), 12'($urandom), 5'($urandom % 31), 16'h0);
        end

        chk("R6 malformed frames", 32'(bad_frames), 32'd0);
        chk("R7 MDC timing violations", 32'(timing_viol), 32'd0);
        report();
    end
endmodule